// File: doc/BRIEF.md
# Port Pin Alternate-Function Controller

This block sits between the upper four bits of a general-purpose port (bits 4 to 7) and the pads. After reset, each of the four bits is an ordinary port bit that shows the value software last wrote to the port latch. Two one-shot commands from the instruction decoder can switch these bits to other uses. The enable-flags command (opcode 0xF5) turns bits 4 and 5 into host interrupt flags that follow the output-buffer-full and input-buffer-full status. The enable-DMA command (opcode 0xE5) turns bit 6 into a DMA request output and bit 7 into a DMA acknowledge input.

In DMA mode, software raises the request by writing 1 to bit 6. The host's acknowledged read or write cycle drops the request on the trailing edge of the strobe, and a fresh enable-DMA command also drops it. While DMA mode is on, the acknowledge pin also selects the buffer registers in the same way as the host chip select does. The external reset request passes through a two-flop synchronizer. The result drives every register of the block and is also made available to the rest of the chip.

Top module: `port_altfn_ctrl`

## Requirements
- R1: One clock after the synchronized reset is released, both modes are off, the port latch holds 4'b1111, `pin_out` equals 4'b1111 and `pin_oe` equals 4'b1111.
- R2: `sys_rst_n` follows `rst_in_n` with a delay of exactly two rising clock edges.
- R3: In flag mode, `pin_out[0]` (port bit 4) equals `obf` when latch bit 4 is 1, and is 0 when latch bit 4 is 0.
- R4: In flag mode, `pin_out[1]` (port bit 5) equals the inverse of `ibf` when latch bit 5 is 1, and is 0 when latch bit 5 is 0.
- R5: In DMA mode, `pin_oe[3]` is 0, so port bit 7 becomes the active-low acknowledge input `p7_in`, and `pin_out[3]` is 1. `pin_out[2]` (port bit 6) carries the request.
- R6: In DMA mode, a port write with `port_wdata[2]` (port bit 6) equal to 1 sets the request on that clock edge. A write of 0 to that bit leaves the request unchanged.
- R7: When `host_rd_n` or `host_wr_n` goes from low to high while `p7_in` was low on the previous clock, the request is 0 after that same edge. Clearing takes priority over a write that would set the request.
- R8: An enable-DMA command clears the request on its clock edge, and it does so even when DMA mode is already on.
- R9: `buf_cs_n` equals `host_cs_n & p7_in` in DMA mode and equals `host_cs_n` otherwise.
- R10: A mode stays on until the next reset once its command has been given. Any bit not taken by an active mode drives its latch value, with `pin_oe` set to 1.
- R11: The request stays 0 while DMA mode is off, whatever is written to bit 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_in_n | input | 1 | Asynchronous active-low reset request |
| sys_rst_n | output | 1 | Synchronized active-low reset |
| port_wr | input | 1 | Port latch write strobe, one clock |
| port_wdata | input | 4 | Latch data for port bits 7..4 (index 0 is bit 4) |
| cmd_en_flags | input | 1 | Enable-flags command pulse |
| cmd_en_dma | input | 1 | Enable-DMA command pulse |
| ibf | input | 1 | Input buffer full status |
| obf | input | 1 | Output buffer full status |
| host_rd_n | input | 1 | Host read strobe, active low |
| host_wr_n | input | 1 | Host write strobe, active low |
| host_cs_n | input | 1 | Host chip select, active low |
| p7_in | input | 1 | Pad input of port bit 7 (active-low acknowledge in DMA mode) |
| pin_out | output | 4 | Pad output values for port bits 7..4 |
| pin_oe | output | 4 | Pad output enables for port bits 7..4 |
| buf_cs_n | output | 1 | Buffer register select to the buffer logic, active low |

## Verification
Timing of the results:
- The pin multiplexer and the buffer select are combinational. They reflect the flag status, the chip select and the acknowledge pin within the same cycle as those inputs change.
- Latch writes, mode commands and request set or clear take effect on the first rising edge that samples them.
- The reset output lags its input by two edges.

How the checks keep to this timing:
- The bench drives every input just after a falling edge, waits through one rising edge, and compares all outputs at the next falling edge.
- At that point it has already stepped its own model of latch, modes and request by that one edge.
- The reset-delay check samples the output after the first edge and again after the second.

// File: rtl/paf_pkg.sv
// Package: shared indices and types for the port alternate-function controller.
// Assumes the controlled slice is port bits 7..4, held at indices 3..0.
package paf_pkg;
    localparam int unsigned NPIN    = 4;
    localparam int unsigned IX_OBF  = 0;   // port bit 4
    localparam int unsigned IX_IBF  = 1;   // port bit 5
    localparam int unsigned IX_DRQ  = 2;   // port bit 6
    localparam int unsigned IX_DACK = 3;   // port bit 7

    typedef struct packed {
        logic flags;
        logic dma;
    } mode_t;
endpackage

// File: rtl/paf_rst_sync.sv
// Reset synchronizer: shifts the external reset request through STAGES flops.
// Assumes STAGES >= 2. The flops have no reset of their own because they produce it.
module paf_rst_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_in_n,
    output logic rst_n
);
    logic [STAGES-1:0] chain;

    // Shift the raw request one stage per clock.
    always_ff @(posedge clk) begin
        chain <= {chain[STAGES-2:0], rst_in_n};
    end

    assign rst_n = chain[STAGES-1];
endmodule

// File: rtl/paf_mode_ctl.sv
// Mode and latch holder: stores the software port latch and the two sticky
// mode flags. Assumes the command pulses last one clock each.
module paf_mode_ctl
    import paf_pkg::*;
#(
    parameter logic [NPIN-1:0] LATCH_INIT = '1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            port_wr,
    input  logic [NPIN-1:0] port_wdata,
    input  logic            cmd_en_flags,
    input  logic            cmd_en_dma,
    output logic [NPIN-1:0] latch,
    output mode_t           mode
);
    // Capture software writes to the port latch.
    always_ff @(posedge clk) begin
        if (!rst_n)       latch <= LATCH_INIT;
        else if (port_wr) latch <= port_wdata;
    end

    // Set the mode flags on their commands; only reset clears them.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode <= '0;
        end else begin
            if (cmd_en_flags) mode.flags <= 1'b1;
            if (cmd_en_dma)   mode.dma   <= 1'b1;
        end
    end

    // R10: modes are sticky.
    p_flags_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        mode.flags |=> mode.flags);
    p_dma_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        mode.dma |=> mode.dma);
endmodule

// File: rtl/paf_drq_ctl.sv
// DMA request flop: software sets it, and the acknowledged host strobe
// trailing edge or a fresh enable-DMA command clears it.
// Assumes the host strobes and the acknowledge pin are already synchronous to clk.
module paf_drq_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic dma_on,
    input  logic cmd_en_dma,
    input  logic port_wr,
    input  logic set_bit,
    input  logic rd_n,
    input  logic wr_n,
    input  logic dack_n,
    output logic drq
);
    logic rd_q, wr_q, dack_q;
    logic ack_end;

    // Keep last-cycle copies of the strobes and the acknowledge pin.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q   <= 1'b1;
            wr_q   <= 1'b1;
            dack_q <= 1'b1;
        end else begin
            rd_q   <= rd_n;
            wr_q   <= wr_n;
            dack_q <= dack_n;
        end
    end

    // Trailing edge of a strobe that was acknowledged.
    assign ack_end = ((rd_n & ~rd_q) | (wr_n & ~wr_q)) & ~dack_q;

    // Request flop: clearing wins over setting.
    always_ff @(posedge clk) begin
        if (!rst_n)                            drq <= 1'b0;
        else if (cmd_en_dma || ack_end)        drq <= 1'b0;
        else if (dma_on && port_wr && set_bit) drq <= 1'b1;
    end

    p_ack_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ack_end |=> !drq);
    p_cmd_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_en_dma |=> !drq);
    p_idle_low_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !dma_on |-> !drq);
    p_zero_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (port_wr && !set_bit && !cmd_en_dma) |=> (drq == $past(drq) || !drq));
endmodule

// File: rtl/paf_pin_mux.sv
// Pin multiplexer: picks, for each port bit, the latch value or its
// alternate function. It also forms the buffer select. Purely combinational.
module paf_pin_mux
    import paf_pkg::*;
(
    input  logic [NPIN-1:0] latch,
    input  mode_t           mode,
    input  logic            obf,
    input  logic            ibf,
    input  logic            drq,
    input  logic            cs_n,
    input  logic            dack_n,
    output logic [NPIN-1:0] pin_out,
    output logic [NPIN-1:0] pin_oe,
    output logic            buf_cs_n
);
    for (genvar i = 0; i < NPIN; i++) begin : g_pin
        if (i == IX_OBF) begin : g_obf
            // Bit 4: gated output-full flag in flag mode.
            assign pin_out[i] = mode.flags ? (latch[i] & obf) : latch[i];
            assign pin_oe[i]  = 1'b1;
        end else if (i == IX_IBF) begin : g_ibf
            // Bit 5: gated inverse input-full flag in flag mode.
            assign pin_out[i] = mode.flags ? (latch[i] & ~ibf) : latch[i];
            assign pin_oe[i]  = 1'b1;
        end else if (i == IX_DRQ) begin : g_drq
            // Bit 6: request output in DMA mode.
            assign pin_out[i] = mode.dma ? drq : latch[i];
            assign pin_oe[i]  = 1'b1;
        end else begin : g_dack
            // Bit 7: released to input in DMA mode.
            assign pin_out[i] = mode.dma ? 1'b1 : latch[i];
            assign pin_oe[i]  = ~mode.dma;
        end
    end

    // The acknowledge pin selects the buffer registers as the chip select does.
    assign buf_cs_n = mode.dma ? (cs_n & dack_n) : cs_n;
endmodule

// File: rtl/port_altfn_ctrl.sv
// Top: alternate-function control for port bits 7..4. It synchronizes the
// reset, keeps the latch and modes, runs the DMA request and muxes the pins.
// Assumes all inputs except rst_in_n are synchronous to clk.
module port_altfn_ctrl
    import paf_pkg::*;
#(
    parameter int unsigned     SYNC_STAGES = 2,
    parameter logic [NPIN-1:0] LATCH_INIT  = '1
) (
    input  logic            clk,
    input  logic            rst_in_n,
    output logic            sys_rst_n,
    input  logic            port_wr,
    input  logic [NPIN-1:0] port_wdata,
    input  logic            cmd_en_flags,
    input  logic            cmd_en_dma,
    input  logic            ibf,
    input  logic            obf,
    input  logic            host_rd_n,
    input  logic            host_wr_n,
    input  logic            host_cs_n,
    input  logic            p7_in,
    output logic [NPIN-1:0] pin_out,
    output logic [NPIN-1:0] pin_oe,
    output logic            buf_cs_n
);
    logic [NPIN-1:0] latch;
    mode_t           mode;
    logic            drq;

    paf_rst_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_in_n(rst_in_n), .rst_n(sys_rst_n)
    );

    paf_mode_ctl #(.LATCH_INIT(LATCH_INIT)) u_mode (
        .clk(clk), .rst_n(sys_rst_n), .port_wr(port_wr), .port_wdata(port_wdata),
        .cmd_en_flags(cmd_en_flags), .cmd_en_dma(cmd_en_dma),
        .latch(latch), .mode(mode)
    );

    paf_drq_ctl u_drq (
        .clk(clk), .rst_n(sys_rst_n), .dma_on(mode.dma), .cmd_en_dma(cmd_en_dma),
        .port_wr(port_wr), .set_bit(port_wdata[IX_DRQ]),
        .rd_n(host_rd_n), .wr_n(host_wr_n), .dack_n(p7_in), .drq(drq)
    );

    paf_pin_mux u_mux (
        .latch(latch), .mode(mode), .obf(obf), .ibf(ibf), .drq(drq),
        .cs_n(host_cs_n), .dack_n(p7_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .buf_cs_n(buf_cs_n)
    );

    p_obf_low_r3: assert property (@(posedge clk) disable iff (!sys_rst_n)
        (mode.flags && !latch[IX_OBF]) |-> !pin_out[IX_OBF]);
    p_ibf_inv_r4: assert property (@(posedge clk) disable iff (!sys_rst_n)
        (mode.flags && latch[IX_IBF]) |-> (pin_out[IX_IBF] != ibf));
    p_dack_in_r5: assert property (@(posedge clk) disable iff (!sys_rst_n)
        mode.dma |-> !pin_oe[IX_DACK]);
    p_cs_pass_r9: assert property (@(posedge clk) disable iff (!sys_rst_n)
        !host_cs_n |-> !buf_cs_n);
    p_reset_state_r1: assert property (@(posedge clk)
        !sys_rst_n |=> (sys_rst_n || (mode == '0 && latch == LATCH_INIT)));
endmodule

// File: tb/port_altfn_ctrl_tb.sv
module port_altfn_ctrl_tb;
    logic       clk = 1'b0;
    logic       rst_in_n = 1'b0;
    logic       sys_rst_n;
    logic       d_wr = 0, d_fl = 0, d_dm = 0, d_ibf = 0, d_obf = 0;
    logic [3:0] d_wd = 0;
    logic       d_rd_n = 1, d_hw_n = 1, d_cs_n = 1, d_dack = 1;
    logic [3:0] pin_out, pin_oe;
    logic       buf_cs_n;

    int total = 0, bad = 0;
    logic [3:0] m_latch;
    logic m_flags, m_dma, m_drq, m_rd, m_hw, m_dack;

    always #4 clk = ~clk;   // 125 MHz

    port_altfn_ctrl u_dut (
        .clk(clk), .rst_in_n(rst_in_n), .sys_rst_n(sys_rst_n),
        .port_wr(d_wr), .port_wdata(d_wd), .cmd_en_flags(d_fl), .cmd_en_dma(d_dm),
        .ibf(d_ibf), .obf(d_obf), .host_rd_n(d_rd_n), .host_wr_n(d_hw_n),
        .host_cs_n(d_cs_n), .p7_in(d_dack),
        .pin_out(pin_out), .pin_oe(pin_oe), .buf_cs_n(buf_cs_n)
    );

    task automatic chk(input logic [3:0] act, input logic [3:0] exp, input string tag);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%b expected=%b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        m_latch = 4'hF; m_flags = 0; m_dma = 0; m_drq = 0;
        m_rd = 1; m_hw = 1; m_dack = 1;
    endtask

    // Advance the model by one edge, using the inputs held through it.
    task automatic model_step();
        logic ack;
        ack = ((d_rd_n & ~m_rd) | (d_hw_n & ~m_hw)) & ~m_dack;
        if (d_dm || ack) m_drq = 0;
        else if (m_dma && d_wr && d_wd[2]) m_drq = 1;
        if (d_wr) m_latch = d_wd;
        if (d_fl) m_flags = 1;
        if (d_dm) m_dma = 1;
        m_rd = d_rd_n; m_hw = d_hw_n; m_dack = d_dack;
    endtask

    function automatic logic [3:0] exp_out();
        logic [3:0] e;
        e[0] = m_flags ? (m_latch[0] & d_obf) : m_latch[0];
        e[1] = m_flags ? (m_latch[1] & ~d_ibf) : m_latch[1];
        e[2] = m_dma ? m_drq : m_latch[2];
        e[3] = m_dma ? 1'b1 : m_latch[3];
        return e;
    endfunction

    task automatic check_all();
        logic [3:0] e;
        e = exp_out();
        chk({3'b0, pin_out[0]}, {3'b0, e[0]}, m_flags ? "R3 obf pin" : "R10 bit4 latch");
        chk({3'b0, pin_out[1]}, {3'b0, e[1]}, m_flags ? "R4 ibf pin" : "R10 bit5 latch");
        chk({3'b0, pin_out[2]}, {3'b0, e[2]}, m_dma ? "R6 drq pin" : "R11 bit6 latch");
        chk({3'b0, pin_out[3]}, {3'b0, e[3]}, m_dma ? "R5 bit7 out" : "R10 bit7 latch");
        chk(pin_oe, {~m_dma, 3'b111}, m_dma ? "R5 oe" : "R10 oe");
        chk({3'b0, buf_cs_n}, {3'b0, m_dma ? (d_cs_n & d_dack) : d_cs_n}, "R9 buf_cs_n");
    endtask

    task automatic step();
        @(posedge clk); @(negedge clk);
        model_step();
        check_all();
        d_wr = 0; d_fl = 0; d_dm = 0;
    endtask

    task automatic idle_host();
        d_rd_n = 1; d_hw_n = 1; d_cs_n = 1; d_dack = 1;
    endtask

    task automatic rand_inputs(input bit allow_cmd);
        d_wr   = ($urandom % 3) == 0;
        d_wd   = 4'($urandom);
        d_ibf  = 1'($urandom);
        d_obf  = 1'($urandom);
        d_rd_n = ($urandom % 4) != 0;
        d_hw_n = ($urandom % 4) != 0;
        d_cs_n = 1'($urandom);
        d_dack = ($urandom % 3) != 0;
        d_fl   = allow_cmd && (($urandom % 80) == 0);
        d_dm   = allow_cmd && (($urandom % 80) == 0);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        bad++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        void'($urandom(32'd4242));
        repeat (5) @(negedge clk);
        rst_in_n = 1;
        repeat (4) @(negedge clk);
        model_reset();
        // R1 reset state
        chk(pin_out, 4'b1111, "R1 pin_out after reset");
        chk(pin_oe, 4'b1111, "R1 pin_oe after reset");
        check_all();

        // Plain port phase: no commands (R10, R11)
        for (int i = 0; i < 300; i++) begin rand_inputs(0); step(); end
        // Writing bit 6 without DMA mode keeps request off
        d_wr = 1; d_wd = 4'b0100; step();
        chk({3'b0, pin_out[2]}, 4'b0001, "R11 bit6 plain");

        // Flag mode, directed
        idle_host();
        d_fl = 1; step();
        d_wr = 1; d_wd = 4'b0000; d_obf = 1; d_ibf = 0; step();
        chk(pin_out[1:0], 2'b00, "R3 R4 latch zero holds low");
        d_wr = 1; d_wd = 4'b0011; d_obf = 1; d_ibf = 0; step();
        chk(pin_out[1:0], 2'b11, "R3 R4 latch one obf=1 ibf=0");
        d_obf = 0; d_ibf = 1; step();
        chk(pin_out[1:0], 2'b00, "R3 R4 latch one obf=0 ibf=1");

        // DMA mode, directed
        d_dm = 1; step();
        chk({3'b0, pin_oe[3]}, 4'b0000, "R5 bit7 input");
        d_wr = 1; d_wd = 4'b0100; step();
        chk({3'b0, pin_out[2]}, 4'b0001, "R6 set");
        d_wr = 1; d_wd = 4'b0000; step();
        chk({3'b0, pin_out[2]}, 4'b0001, "R6 zero write no effect");
        d_rd_n = 0; d_dack = 1; step();
        d_rd_n = 1; step();
        chk({3'b0, pin_out[2]}, 4'b0001, "R7 unacked read keeps drq");
        d_rd_n = 0; d_dack = 0; d_cs_n = 1; step();
        chk({3'b0, buf_cs_n}, 4'b0000, "R9 dack selects");
        chk({3'b0, pin_out[2]}, 4'b0001, "R7 drq held during strobe");
        d_rd_n = 1; d_wr = 1; d_wd = 4'b0100; step();
        chk({3'b0, pin_out[2]}, 4'b0000, "R7 read trailing edge clears");
        d_dack = 1; d_wr = 1; d_wd = 4'b0100; step();
        d_hw_n = 0; d_dack = 0; step();
        d_hw_n = 1; step();
        chk({3'b0, pin_out[2]}, 4'b0000, "R7 write trailing edge clears");
        d_dack = 1; d_wr = 1; d_wd = 4'b0100; step();
        d_dm = 1; step();
        chk({3'b0, pin_out[2]}, 4'b0000, "R8 re-enable clears");

        // Mixed random phase
        for (int i = 0; i < 3000; i++) begin rand_inputs(1); step(); end

        // R2: reset synchronizer delay, then R1 again
        idle_host(); d_wr = 0; d_fl = 0; d_dm = 0;
        rst_in_n = 0;
        @(posedge clk); @(negedge clk);
        chk({3'b0, sys_rst_n}, 4'b0001, "R2 one edge still high");
        @(posedge clk); @(negedge clk);
        chk({3'b0, sys_rst_n}, 4'b0000, "R2 two edges low");
        rst_in_n = 1;
        @(posedge clk); @(negedge clk);
        chk({3'b0, sys_rst_n}, 4'b0000, "R2 release one edge");
        @(posedge clk); @(negedge clk);
        chk({3'b0, sys_rst_n}, 4'b0001, "R2 release two edges");
        @(posedge clk); @(negedge clk);
        model_reset();
        chk(pin_out, 4'b1111, "R1 pin_out after second reset");
        chk(pin_oe, 4'b1111, "R1 pin_oe after second reset");
        check_all();

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule